// File: doc/BRIEF.md
# Byte-Wide ROM Pulse-and-Verify Programming Sequencer

This block programs a byte-wide, one-time or erasable programmable ROM, one address at a time. A single start request launches a walk from address zero to the last address. At each address the sequencer drives the address and the wanted byte and waits a settling interval. It then fires one timed active-low pulse on the chip-enable line while output enable stays high, waits a recovery interval and reads the byte back. If the byte matches, it moves on to the next address. If it does not, it fires another pulse. After a bounded number of pulses without a match, it gives up and reports the device as failed.

Once every address has programmed, the sequencer drops the programming-supply request and raises the normal-verify supply request. It then reads every byte once more in ascending address order. The first disagreement ends the run as a failure; full agreement ends it as a pass. The wanted byte for each address comes from an external data source, which answers combinationally for whatever address the sequencer currently drives. The supply rails are not controlled here, only requested through two flags.

Pulse width is set in microseconds and converted to clock cycles from the clock frequency parameter. The default is 100 us at 50 MHz, which gives 5000 cycles. The setup delay, the recovery delay and the pulse limit (default 25) are also parameters.

Top module: `prom_prog_seq`

## Requirements
- R1: Out of reset and whenever idle: chip enable and output enable are high (inactive), the data bus is not driven, both supply requests are low, and busy and done are low.
- R2: A start request taken while idle begins at address 0 with the pulse count cleared and the programming-supply request raised; busy stays high from the cycle after start until the cycle done is high, inclusive.
- R3: Every program pulse holds chip enable low for exactly PULSE_CYC = CLK_KHZ*PULSE_US/1000 consecutive cycles, with output enable high and the wanted byte driven on the data bus.
- R4: The address and data outputs stay unchanged and driven for at least SETUP_CYC cycles before a pulse begins and for the whole pulse. Exactly RECOV_CYC cycles with chip enable high separate the end of a pulse from the following verify read.
- R5: A verify read takes one cycle with chip enable and output enable both low and the data bus released; a matching byte makes the sequencer advance to the next address, so a byte needing k pulses receives exactly k pulses.
- R6: A mismatching byte gets another pulse at the same address; no address receives more than MAX_PULSES pulses. A mismatch after the last allowed pulse ends the run with pass low and the failing address reported.
- R7: After the last address verifies, the programming-supply request falls and the verify-supply request rises (never both high). Each address is then read exactly once in ascending order. The first mismatch ends the run with pass low and that address reported; no mismatch ends it with pass high.
- R8: Done is high for exactly one cycle, after which the sequencer is idle. Pass and the reported failing address hold their values until the next start. The run takes P*(SETUP_CYC+PULSE_CYC+RECOV_CYC+1) cycles for P pulses in total, plus SETUP_CYC plus the number of final reads when programming succeeds.
- R9: A start request while busy is ignored: the run continues unchanged and its duration and results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only while idle |
| src_data_i | input | DATA_W | Wanted byte for the address on dev_addr_o |
| dev_addr_o | output | ADDR_W | Address to the ROM |
| dev_dq_o | output | DATA_W | Data driven to the ROM during programming |
| dev_dq_oe_o | output | 1 | Data-bus drive enable |
| dev_dq_i | input | DATA_W | Data read from the ROM |
| dev_ce_n_o | output | 1 | Active-low chip enable (program pulse and read strobe) |
| dev_oe_n_o | output | 1 | Active-low output enable |
| prog_supply_o | output | 1 | Request for programming supply levels |
| verify_supply_o | output | 1 | Request for normal verify supply levels |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| pass_o | output | 1 | Result of the last run, held until the next start |
| fail_addr_o | output | ADDR_W | Address that failed in the last run |

## Verification
The assertions assume that the ROM answers a read within the same cycle in which chip enable and output enable are low. They also assume that the data source returns a value that depends only on the driven address, so the byte is steady whenever the address is. The bench satisfies both. Its ROM model returns the stored byte combinationally during a read cycle. Its data source is a table indexed by the address output. The model changes stored contents only at the end of a pulse or when the verify-supply request rises, both of which fall outside a read cycle.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV,
        ST_CHECK,
        ST_FSETUP,
        ST_FREAD,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // a freshly loaded non-zero interval must not read as expired next cycle
    assert_load_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && val_i != '0) |=> !zero_o);

endmodule

// File: rtl/prog_pulse_ctr.sv
module prog_pulse_ctr #(
    parameter int W     = 5,
    parameter int LIMIT = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         limit_o
);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o   = cnt_q;
    assign limit_o = (cnt_q == LIM_V);

    assert_no_extra_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |-> (cnt_q < LIM_V));

endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
    import prom_prog_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_KHZ    = 50000,
    parameter int PULSE_US   = 100,
    parameter int SETUP_CYC  = 4,
    parameter int RECOV_CYC  = 4,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [DATA_W-1:0] dev_dq_o,
    output logic              dev_dq_oe_o,
    input  logic [DATA_W-1:0] dev_dq_i,
    output logic              dev_ce_n_o,
    output logic              dev_oe_n_o,
    output logic              prog_supply_o,
    output logic              verify_supply_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o
);
    localparam int PULSE_CYC = (CLK_KHZ * PULSE_US) / 1000;
    localparam int TMR_MAX   = (PULSE_CYC > SETUP_CYC) ?
                               ((PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC) :
                               ((SETUP_CYC > RECOV_CYC) ? SETUP_CYC : RECOV_CYC);
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam int CNT_W     = $clog2(MAX_PULSES + 1);

    localparam logic [TMR_W-1:0]  T_SETUP   = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0]  T_PULSE   = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  T_RECOV   = TMR_W'(RECOV_CYC - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              pass;
        logic [ADDR_W-1:0] fail_addr;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              cnt_clr, cnt_inc;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_limit;
    logic              byte_ok;

    prog_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    prog_pulse_ctr #(.W(CNT_W), .LIMIT(MAX_PULSES)) u_pulses (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .cnt_o   (cnt_val),
        .limit_o (cnt_limit)
    );

    assign byte_ok = (dev_dq_i == src_data_i);

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st        = ST_SETUP;
                    r_d.addr      = '0;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = '0;
                    cnt_clr       = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = T_SETUP;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.st   = ST_PULSE;
                    cnt_inc  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    r_d.st   = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = T_RECOV;
                end
            end
            ST_RECOV: begin
                if (tmr_zero) r_d.st = ST_CHECK;
            end
            ST_CHECK: begin
                if (byte_ok) begin
                    tmr_load = 1'b1;
                    tmr_val  = T_SETUP;
                    cnt_clr  = 1'b1;
                    if (r_q.addr == LAST_ADDR) begin
                        r_d.st   = ST_FSETUP;
                        r_d.addr = '0;
                    end else begin
                        r_d.st   = ST_SETUP;
                        r_d.addr = r_q.addr + ADDR_W'(1);
                    end
                end else if (cnt_limit) begin
                    r_d.st        = ST_DONE;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = r_q.addr;
                end else begin
                    r_d.st   = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETUP;
                end
            end
            ST_FSETUP: begin
                if (tmr_zero) r_d.st = ST_FREAD;
            end
            ST_FREAD: begin
                if (!byte_ok) begin
                    r_d.st        = ST_DONE;
                    r_d.pass      = 1'b0;
                    r_d.fail_addr = r_q.addr;
                end else if (r_q.addr == LAST_ADDR) begin
                    r_d.st   = ST_DONE;
                    r_d.pass = 1'b1;
                end else begin
                    r_d.addr = r_q.addr + ADDR_W'(1);
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.addr      <= '0;
            r_q.pass      <= 1'b0;
            r_q.fail_addr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dev_addr_o      = r_q.addr;
    assign dev_dq_o        = src_data_i;
    assign dev_dq_oe_o     = (r_q.st == ST_SETUP) || (r_q.st == ST_PULSE);
    assign dev_ce_n_o      = !((r_q.st == ST_PULSE) || (r_q.st == ST_CHECK) ||
                               (r_q.st == ST_FREAD));
    assign dev_oe_n_o      = !((r_q.st == ST_CHECK) || (r_q.st == ST_FREAD));
    assign prog_supply_o   = (r_q.st == ST_SETUP) || (r_q.st == ST_PULSE) ||
                             (r_q.st == ST_RECOV) || (r_q.st == ST_CHECK);
    assign verify_supply_o = (r_q.st == ST_FSETUP) || (r_q.st == ST_FREAD);
    assign busy_o          = (r_q.st != ST_IDLE);
    assign done_o          = (r_q.st == ST_DONE);
    assign pass_o          = r_q.pass;
    assign fail_addr_o     = r_q.fail_addr;

    assert_pulse_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dev_ce_n_o) && dev_oe_n_o) |-> (dev_dq_oe_o && $stable(dev_addr_o)));

    assert_read_releases_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_oe_n_o |-> !dev_dq_oe_o);

    assert_retry_same_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHECK && !byte_ok && !cnt_limit) |=> $stable(dev_addr_o));

    assert_supply_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_supply_o && verify_supply_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);

    assert_pulse_in_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n_o && dev_oe_n_o) |-> (prog_supply_o && cnt_val != '0));

endmodule

// File: tb/prom_prog_seq_tb.sv
module prom_prog_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 3;
    localparam int N    = 1 << AW;
    localparam int KHZ  = 60;
    localparam int PUS  = 100;
    localparam int PCYC = KHZ * PUS / 1000;
    localparam int SCYC = 2;
    localparam int RCYC = 3;
    localparam int MAXP = 25;
    localparam int PER  = SCYC + PCYC + RCYC + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [7:0]    src_data, dq_o, dq_i;
    logic [AW-1:0] addr, fail_addr;
    logic          dq_oe, ce_n, oe_n, prog_s, ver_s, busy, done, pass;

    logic [7:0] mem [N];
    logic [7:0] src_mem [N];
    int need [N];
    int pcount [N];
    int vectors = 0;
    int fails = 0;
    int drift_addr = -1;
    int fexp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign src_data = src_mem[addr];
    assign dq_i     = (!ce_n && !oe_n) ? mem[addr] : 8'h00;

    prom_prog_seq #(
        .ADDR_W(AW), .DATA_W(8), .CLK_KHZ(KHZ), .PULSE_US(PUS),
        .SETUP_CYC(SCYC), .RECOV_CYC(RCYC), .MAX_PULSES(MAXP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_data_i(src_data),
        .dev_addr_o(addr), .dev_dq_o(dq_o), .dev_dq_oe_o(dq_oe), .dev_dq_i(dq_i),
        .dev_ce_n_o(ce_n), .dev_oe_n_o(oe_n), .prog_supply_o(prog_s),
        .verify_supply_o(ver_s), .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_addr_o(fail_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ROM model and protocol monitor, evaluated away from the active edge
    logic [AW-1:0] p_addr, pul_addr;
    logic [7:0]    p_dq, pul_data;
    logic          p_oe, p_vs;
    int stable = 0, width = 0, gap = 0;
    bit in_gap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (addr != p_addr || dq_o != p_dq || dq_oe != p_oe) stable = 0;
            else stable++;
            if (!ce_n && oe_n) begin
                if (width == 0) begin
                    chk(stable >= SCYC, "R4 setup before pulse", stable, SCYC);
                    chk(dq_oe && prog_s, "R3 data driven in pulse", dq_oe, 1);
                    pul_addr = addr;
                    pul_data = dq_o;
                end
                width++;
                if (addr != pul_addr)
                    chk(0, "R4 address moved in pulse", addr, pul_addr);
            end else if (width > 0) begin
                chk(width == PCYC, "R3 pulse width", width, PCYC);
                pcount[pul_addr]++;
                if (pcount[pul_addr] >= need[pul_addr])
                    mem[pul_addr] = mem[pul_addr] & pul_data;
                width = 0;
                in_gap = 1;
                gap = 1;
            end else if (ce_n && in_gap) begin
                gap++;
            end
            if (!ce_n && !oe_n) begin
                if (in_gap) begin
                    chk(gap == RCYC, "R4 recovery gap", gap, RCYC);
                    in_gap = 0;
                end
                if (dq_oe) chk(0, "R5 bus driven during read", dq_oe, 0);
                if (ver_s) begin
                    chk(addr == fexp[AW-1:0], "R7 final read order", addr, fexp);
                    fexp++;
                end
            end
            if (ver_s && !p_vs && drift_addr >= 0)
                mem[drift_addr] = mem[drift_addr] ^ 8'h01;
        end
        p_addr = addr;
        p_dq   = dq_o;
        p_oe   = dq_oe;
        p_vs   = ver_s;
    end

    task automatic run_case(input int seed, input int drift, input bit inject, input string tag);
        int tot, fail_at, t_exp, exp_fail, n_reads, cyc;
        int exp_p [N];
        logic [7:0] d;
        @(posedge clk);
        for (int a = 0; a < N; a++) begin
            mem[a] = 8'hFF;
            pcount[a] = 0;
            d = 8'((a * 29 + seed) & 255);
            if (d == 8'hFF) d = 8'h5A;
            src_mem[a] = d;
        end
        drift_addr = drift;
        fexp = 0;
        tot = 0;
        fail_at = -1;
        for (int a = 0; a < N; a++) begin
            if (fail_at >= 0) exp_p[a] = 0;
            else if (need[a] > MAXP) begin exp_p[a] = MAXP; tot += MAXP; fail_at = a; end
            else begin exp_p[a] = need[a]; tot += need[a]; end
        end
        t_exp = tot * PER;
        n_reads = 0;
        exp_fail = fail_at;
        if (fail_at < 0) begin
            n_reads = (drift >= 0) ? drift + 1 : N;
            exp_fail = drift;
            t_exp += SCYC + n_reads;
        end
        @(negedge clk) start_i = 1'b1;
        @(posedge clk);
        cyc = 0;
        while (1) begin
            @(negedge clk);
            if (cyc == 0) begin
                start_i = 1'b0;
                chk(busy && prog_s && !ver_s, {"R2 start state ", tag}, busy, 1);
                chk(addr == 0, {"R2 first address ", tag}, addr, 0);
            end
            if (inject && cyc == 40) start_i = 1'b1;
            if (inject && cyc == 41) start_i = 1'b0;
            if (done) break;
            if (!busy) begin chk(0, {"R2 busy dropped ", tag}, cyc, t_exp); break; end
            if (cyc > 20000) begin chk(0, {"watchdog run ", tag}, cyc, t_exp); break; end
            @(posedge clk);
            cyc++;
        end
        chk(cyc == t_exp, {"R8 run length ", tag}, cyc, t_exp);
        chk(pass == (exp_fail < 0), {"R7 pass flag ", tag}, pass, exp_fail < 0);
        if (exp_fail >= 0)
            chk(fail_addr == exp_fail[AW-1:0], {"R6 failing address ", tag}, fail_addr, exp_fail);
        chk(fexp == n_reads, {"R7 final read count ", tag}, fexp, n_reads);
        for (int a = 0; a < N; a++)
            chk(pcount[a] == exp_p[a], {"R5 pulses per address ", tag}, pcount[a], exp_p[a]);
        @(negedge clk);
        chk(!done && !busy, {"R8 done single cycle ", tag}, done, 0);
        chk(pass == (exp_fail < 0), {"R8 pass held ", tag}, pass, exp_fail < 0);
        chk(ce_n && oe_n && !dq_oe && !prog_s && !ver_s, {"R1 idle after run ", tag}, ce_n, 1);
        repeat (3) @(negedge clk);
        chk(pass == (exp_fail < 0), {"R8 pass still held ", tag}, pass, exp_fail < 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog global", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) need[a] = 1;
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && !dq_oe, "R1 reset bus idle", ce_n, 1);
        chk(!prog_s && !ver_s && !busy && !done, "R1 reset flags", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && ce_n, "R1 idle after reset", busy, 0);

        // single pulse everywhere, pass
        run_case(3, -1, 1'b0, "one-pulse");
        // varied retry counts up to the limit exactly, pass
        for (int a = 0; a < N; a++) need[a] = a * 3 + 1;
        need[N-1] = MAXP;
        run_case(17, -1, 1'b0, "varied");
        // one address beyond the limit: R6 failure at address 4
        for (int a = 0; a < N; a++) need[a] = 2;
        need[4] = MAXP + 1;
        run_case(41, -1, 1'b0, "limit-exceeded");
        // failure on the last address beyond the limit
        for (int a = 0; a < N; a++) need[a] = 1;
        need[N-1] = MAXP + 3;
        run_case(9, -1, 1'b0, "last-addr-fail");
        // byte drifts once verify supply rises: R7 failure at address 6
        for (int a = 0; a < N; a++) need[a] = 2;
        run_case(77, 6, 1'b0, "final-mismatch");
        // drift at address 0: first final read fails
        run_case(5, 0, 1'b0, "final-mismatch-0");
        // start pulsed mid-run: R9 no effect
        for (int a = 0; a < N; a++) need[a] = 1;
        run_case(3, -1, 1'b1, "R9 start-while-busy");
        // clean pass after failures
        run_case(101, -1, 1'b0, "recovery");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule